// File: doc/BRIEF.md
# RC6-32 Block Cipher Sequencer (20 rounds, 128-bit block)

This block carries out one full RC6 encryption or decryption of a 128-bit block using 32-bit words. The expanded key is not computed here. It sits in an external synchronous memory of 64-bit words, with two subkeys per word. The block walks that memory one word per cycle, applies the opening whitening step, iterates the round function once per clock and applies the closing whitening step. It then raises a completion flag with the result held on its output.

An operation starts when reset is released. On the first clock edge with reset low, the block captures the input block and the direction select. From then on it runs without further input. It finishes after a fixed number of edges. To start another operation, assert reset again. Each memory address is driven one cycle before the subkeys it returns are consumed, which hides the one-cycle read latency.

Top module: `rc6_core`

## Requirements
- R1: With `enc_sel` high at the start, `data_out` equals the RC6-32 encryption of `data_in` under the subkeys held in the memory: pre-whitening B+=S0 and D+=S1, ROUNDS rounds, then post-whitening A+=S[2R+2] and C+=S[2R+3].
- R2: With `enc_sel` low at the start, the block computes the inverse cipher. Decrypting an encrypted block returns the original block bit for bit.
- R3: `enc_sel` and `data_in` are sampled only on the first rising edge after reset is released. Changing either one later has no effect on the result.
- R4: Memory word k carries subkey S[2k] in bits 31:0 and S[2k+1] in bits 63:32. In the capture cycle, `key_addr` is 0 for encryption and ROUNDS+1 (21) for decryption. `key_addr` never exceeds ROUNDS+1.
- R5: Over the cycles n = 0..ROUNDS+1 after reset release (n = number of edges seen with reset low), `key_addr` is n for encryption and ROUNDS+1−n for decryption. Each word is consumed on the cycle after its address is driven.
- R6: `done` first reads high after exactly ROUNDS+3 (23) rising edges with reset low. It rises only on the edge that closes the post-whitening step.
- R7: While reset is high, `done` is 0 and `data_out` is all zeros.
- R8: Once `done` is high, `done` and `data_out` keep their values until reset, whatever the other inputs do.
- R9: The block is packed with A = bits 31:0, B = 63:32, C = 95:64 and D = 127:96, so the first byte of the block is the lowest byte of A.
- R10: With an all-zero 128-bit key and an all-zero block, encryption yields 128'h1ea44898_4edf29c1_78f7b156_36a5c38f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; its release starts an operation |
| enc_sel | input | 1 | 1 = encrypt, 0 = decrypt; sampled in the capture cycle |
| data_in | input | 128 | Block to process, packed as in R9 |
| data_out | output | 128 | Result block, valid while `done` is high |
| done | output | 1 | High once the result is on `data_out` |
| key_addr | output | 5 | Subkey memory word address ($clog2(ROUNDS+2) bits) |
| key_pair | input | 64 | Subkey memory read data, one cycle after `key_addr` |

## Verification
A wrong round count or a misplaced subkey word scrambles nearly every bit of `data_out`. The cipher diffuses strongly, so such a fault cannot stay hidden, but it shows only once, at the `done` edge 23 cycles after release. Faults in the sequencer show much sooner. An address that skips, repeats or walks the wrong way appears on `key_addr` in the very next cycle. A mis-latched direction shows in the capture cycle as the wrong starting address. A phase that ends early or late moves the `done` edge away from edge 23.

// File: rtl/rc6_pkg.sv
package rc6_pkg;

  localparam int WORD_W = 32;
  localparam int ROT_W  = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ROT_W-1:0]  rot_t;

  // packed so that lane a sits in the least significant word
  typedef struct packed {
    word_t d;
    word_t c;
    word_t b;
    word_t a;
  } blk_t;

  typedef enum logic [2:0] {
    PH_LOAD = 3'd0,
    PH_PRE  = 3'd1,
    PH_RUN  = 3'd2,
    PH_POST = 3'd3,
    PH_HOLD = 3'd4
  } phase_t;

  function automatic word_t rol(word_t x, rot_t n);
    logic [2*WORD_W-1:0] y;
    y = {x, x} << n;
    return y[2*WORD_W-1:WORD_W];
  endfunction

  function automatic word_t ror(word_t x, rot_t n);
    logic [2*WORD_W-1:0] y;
    y = {x, x} >> n;
    return y[WORD_W-1:0];
  endfunction

  function automatic rot_t amt(word_t x);
    return x[ROT_W-1:0];
  endfunction

  // x*(2x+1) mod 2^W, rotated left by log2(W)
  function automatic word_t quad_mix(word_t x);
    word_t p;
    p = x * {x[WORD_W-2:0], 1'b1};
    return rol(p, rot_t'(ROT_W));
  endfunction

  function automatic blk_t fwd_round(blk_t s, word_t k_lo, word_t k_hi);
    word_t t, u, na, nc;
    blk_t  r;
    t  = quad_mix(s.b);
    u  = quad_mix(s.d);
    na = rol(s.a ^ t, amt(u)) + k_lo;
    nc = rol(s.c ^ u, amt(t)) + k_hi;
    r.a = s.b;
    r.b = nc;
    r.c = s.d;
    r.d = na;
    return r;
  endfunction

  function automatic blk_t inv_round(blk_t s, word_t k_lo, word_t k_hi);
    word_t t, u;
    blk_t  r;
    r.a = s.d;
    r.b = s.a;
    r.c = s.b;
    r.d = s.c;
    u   = quad_mix(r.d);
    t   = quad_mix(r.b);
    r.c = ror(r.c - k_hi, amt(t)) ^ u;
    r.a = ror(r.a - k_lo, amt(u)) ^ t;
    return r;
  endfunction

  // lanes b/d are touched on forward-entry and inverse-exit, a/c otherwise
  function automatic blk_t whiten(blk_t s, word_t k_lo, word_t k_hi,
                                  logic enc, logic post);
    blk_t r;
    r = s;
    if (enc ^ post) begin
      r.b = enc ? s.b + k_lo : s.b - k_lo;
      r.d = enc ? s.d + k_hi : s.d - k_hi;
    end else begin
      r.a = enc ? s.a + k_lo : s.a - k_lo;
      r.c = enc ? s.c + k_hi : s.c - k_hi;
    end
    return r;
  endfunction

endpackage

// File: rtl/rc6_seq.sv
module rc6_seq
  import rc6_pkg::*;
#(
  parameter int ROUNDS = 20,
  localparam int NPAIRS = ROUNDS + 2,
  localparam int AW = $clog2(NPAIRS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_i,
  output phase_t        phase_o,
  output logic          enc_o,
  output logic [AW-1:0] addr_o
);

  localparam logic [AW-1:0] LAST_PAIR = AW'(NPAIRS - 1);
  localparam logic [AW-1:0] LAST_RND  = AW'(ROUNDS);

  phase_t        phase_q, phase_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          enc_q, enc_d;

  function automatic logic [AW-1:0] pair_at(logic e, logic [AW-1:0] k);
    return e ? k : LAST_PAIR - k;
  endfunction

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    enc_d   = enc_q;
    addr_o  = pair_at(enc_q, cnt_q);
    unique case (phase_q)
      PH_LOAD: begin
        enc_d   = sel_i;
        cnt_d   = '0;
        addr_o  = pair_at(sel_i, '0);
        phase_d = PH_PRE;
      end
      PH_PRE: begin
        addr_o  = pair_at(enc_q, cnt_q + 1'b1);
        cnt_d   = cnt_q + 1'b1;
        phase_d = PH_RUN;
      end
      PH_RUN: begin
        addr_o = pair_at(enc_q, cnt_q + 1'b1);
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST_RND) phase_d = PH_POST;
      end
      PH_POST: phase_d = PH_HOLD;
      default: phase_d = PH_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      enc_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      enc_q   <= enc_d;
    end
  end

  assign phase_o = phase_q;
  assign enc_o   = enc_q;

endmodule

// File: rtl/rc6_round.sv
module rc6_round
  import rc6_pkg::*;
(
  input  blk_t                  blk_i,
  input  logic [2*WORD_W-1:0]   pair_i,
  input  logic                  enc_i,
  output blk_t                  blk_o
);

  word_t k_lo, k_hi;
  blk_t  fwd, inv;

  assign k_lo  = pair_i[WORD_W-1:0];
  assign k_hi  = pair_i[2*WORD_W-1:WORD_W];
  assign fwd   = fwd_round(blk_i, k_lo, k_hi);
  assign inv   = inv_round(blk_i, k_lo, k_hi);
  assign blk_o = enc_i ? fwd : inv;

endmodule

// File: rtl/rc6_whiten.sv
module rc6_whiten
  import rc6_pkg::*;
(
  input  blk_t                  blk_i,
  input  logic [2*WORD_W-1:0]   pair_i,
  input  logic                  enc_i,
  input  logic                  post_i,
  output blk_t                  blk_o
);

  assign blk_o = whiten(blk_i, pair_i[WORD_W-1:0],
                        pair_i[2*WORD_W-1:WORD_W], enc_i, post_i);

endmodule

// File: rtl/rc6_core.sv
module rc6_core
  import rc6_pkg::*;
#(
  parameter int ROUNDS = 20,
  localparam int AW = $clog2(ROUNDS + 2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enc_sel,
  input  logic [4*WORD_W-1:0]   data_in,
  output logic [4*WORD_W-1:0]   data_out,
  output logic                  done,
  output logic [AW-1:0]         key_addr,
  input  logic [2*WORD_W-1:0]   key_pair
);

  phase_t phase;
  logic   dir_enc;
  logic   ev_load, ev_pre, ev_run, ev_post;
  blk_t   st_q, wh_out, rnd_out;
  logic [4*WORD_W-1:0] out_q;
  logic   done_q;

  rc6_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (enc_sel),
    .phase_o (phase),
    .enc_o   (dir_enc),
    .addr_o  (key_addr)
  );

  assign ev_load = (phase == PH_LOAD);
  assign ev_pre  = (phase == PH_PRE);
  assign ev_run  = (phase == PH_RUN);
  assign ev_post = (phase == PH_POST);

  rc6_whiten u_whiten (
    .blk_i  (st_q),
    .pair_i (key_pair),
    .enc_i  (dir_enc),
    .post_i (ev_post),
    .blk_o  (wh_out)
  );

  rc6_round u_round (
    .blk_i  (st_q),
    .pair_i (key_pair),
    .enc_i  (dir_enc),
    .blk_o  (rnd_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      out_q  <= '0;
      done_q <= 1'b0;
    end else if (ev_load) begin
      st_q <= data_in;
    end else if (ev_pre) begin
      st_q <= wh_out;
    end else if (ev_run) begin
      st_q <= rnd_out;
    end else if (ev_post) begin
      out_q  <= wh_out;
      done_q <= 1'b1;
    end
  end

  assign data_out = out_q;
  assign done     = done_q;

endmodule

// File: rtl/rc6_core_chk.sv
module rc6_core_chk #(
  parameter int ROUNDS = 20,
  parameter int DW = 128,
  localparam int NPAIRS = ROUNDS + 2,
  localparam int AW = $clog2(NPAIRS)
) (
  input logic          clk,
  input logic          rst,
  input logic          enc_sel,
  input logic          done,
  input logic [DW-1:0] data_out,
  input logic [AW-1:0] key_addr,
  input logic          dir_enc,
  input logic          ev_load,
  input logic          ev_pre,
  input logic          ev_run,
  input logic          ev_post
);

  localparam logic [AW-1:0] TOP = AW'(NPAIRS - 1);

  p_first_pair_r4: assert property (@(posedge clk) disable iff (rst)
    ev_load |-> key_addr == (enc_sel ? '0 : TOP));

  p_addr_bound_r4: assert property (@(posedge clk) disable iff (rst)
    key_addr <= TOP);

  p_fwd_walk_r5: assert property (@(posedge clk) disable iff (rst)
    ((ev_pre || ev_run) && dir_enc && key_addr != TOP)
      |=> key_addr == $past(key_addr) + 1'b1);

  p_rev_walk_r5: assert property (@(posedge clk) disable iff (rst)
    ((ev_pre || ev_run) && !dir_enc && key_addr != '0)
      |=> key_addr == $past(key_addr) - 1'b1);

  p_dir_capture_r3: assert property (@(posedge clk) disable iff (rst)
    ev_load |=> dir_enc == $past(enc_sel));

  p_dir_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    !ev_load |=> $stable(dir_enc));

  p_done_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(ev_post));

  p_one_phase_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_load, ev_pre, ev_run, ev_post}));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(data_out));

endmodule

bind rc6_core rc6_core_chk #(.ROUNDS(ROUNDS), .DW(4*rc6_pkg::WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enc_sel  (enc_sel),
  .done     (done),
  .data_out (data_out),
  .key_addr (key_addr),
  .dir_enc  (dir_enc),
  .ev_load  (ev_load),
  .ev_pre   (ev_pre),
  .ev_run   (ev_run),
  .ev_post  (ev_post)
);

// File: tb/rc6_core_bench.sv
module rc6_core_bench;

  localparam int ROUNDS = 20;
  localparam int NPAIRS = ROUNDS + 2;
  localparam int AW     = $clog2(NPAIRS);
  localparam int NSUB   = 2 * NPAIRS;
  localparam int LAT    = ROUNDS + 3;
  localparam int NVEC   = 4;

  // key, plaintext, published ciphertext, whether that ciphertext is known
  localparam logic [127:0] VKEY [NVEC] = '{
    128'h0,
    128'h0,
    128'h78675645_34231201_efcdab89_67452301,
    {128{1'b1}}
  };
  localparam logic [127:0] VPT [NVEC] = '{
    128'h0,
    128'hdeadbeef_00c0ffee_13572468_a5a5a5a5,
    128'hf1e0dfce_bdac9b8a_79685746_35241302,
    {128{1'b1}}
  };
  localparam logic [127:0] VCT [NVEC] = '{
    128'h1ea44898_4edf29c1_78f7b156_36a5c38f,
    128'h0,
    128'h183fa47e_36f6511f_23c61547_2f194e52,
    128'h0
  };
  localparam bit VKNOWN [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b1;
  logic [127:0]  din = '0;
  logic [127:0]  dout;
  logic          done;
  logic [AW-1:0] rom_addr;
  logic [63:0]   rom_q;
  logic [63:0]   rom_mem [NPAIRS];
  logic [31:0]   sk [NSUB];
  int            n_chk = 0;
  int            n_fail = 0;

  always #4 clk = ~clk;

  always @(posedge clk) rom_q <= rom_mem[rom_addr];

  rc6_core #(.ROUNDS(ROUNDS)) u_rc6_core (
    .clk      (clk),
    .rst      (rst),
    .enc_sel  (sel),
    .data_in  (din),
    .data_out (dout),
    .done     (done),
    .key_addr (rom_addr),
    .key_pair (rom_q)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(logic [31:0] x, logic [4:0] n);
    if (n == 5'd0) return x;
    return (x << n) | (x >> (6'd32 - {1'b0, n}));
  endfunction

  function automatic logic [31:0] rr(logic [31:0] x, logic [4:0] n);
    if (n == 5'd0) return x;
    return (x >> n) | (x << (6'd32 - {1'b0, n}));
  endfunction

  function automatic logic [31:0] sq(logic [31:0] x);
    logic [31:0] m;
    m = x + x + 32'd1;
    return rl(x * m, 5'd5);
  endfunction

  task automatic set_key(input logic [127:0] key);
    logic [31:0] lw [4];
    logic [31:0] a, b, ab;
    int i, j;
    for (int q = 0; q < 4; q++) lw[q] = key[32*q +: 32];
    sk[0] = 32'hB7E15163;
    for (int q = 1; q < NSUB; q++) sk[q] = sk[q-1] + 32'h9E3779B9;
    a = '0; b = '0; i = 0; j = 0;
    for (int s = 0; s < 3 * NSUB; s++) begin
      a = rl(sk[i] + a + b, 5'd3);
      sk[i] = a;
      ab = a + b;
      b = rl(lw[j] + ab, ab[4:0]);
      lw[j] = b;
      i = (i + 1) % NSUB;
      j = (j + 1) % 4;
    end
    for (int k = 0; k < NPAIRS; k++) rom_mem[k] = {sk[2*k+1], sk[2*k]};
  endtask

  function automatic logic [127:0] ref_enc(logic [127:0] p);
    logic [31:0] w [4];
    logic [31:0] t, u, tmp;
    for (int q = 0; q < 4; q++) w[q] = p[32*q +: 32];
    w[1] = w[1] + sk[0];
    w[3] = w[3] + sk[1];
    for (int i = 1; i <= ROUNDS; i++) begin
      t = sq(w[1]);
      u = sq(w[3]);
      w[0] = rl(w[0] ^ t, u[4:0]) + sk[2*i];
      w[2] = rl(w[2] ^ u, t[4:0]) + sk[2*i+1];
      tmp = w[0]; w[0] = w[1]; w[1] = w[2]; w[2] = w[3]; w[3] = tmp;
    end
    w[0] = w[0] + sk[2*ROUNDS+2];
    w[2] = w[2] + sk[2*ROUNDS+3];
    return {w[3], w[2], w[1], w[0]};
  endfunction

  function automatic logic [127:0] ref_dec(logic [127:0] c);
    logic [31:0] w [4];
    logic [31:0] t, u, tmp;
    for (int q = 0; q < 4; q++) w[q] = c[32*q +: 32];
    w[2] = w[2] - sk[2*ROUNDS+3];
    w[0] = w[0] - sk[2*ROUNDS+2];
    for (int i = ROUNDS; i >= 1; i--) begin
      tmp = w[3]; w[3] = w[2]; w[2] = w[1]; w[1] = w[0]; w[0] = tmp;
      u = sq(w[3]);
      t = sq(w[1]);
      w[2] = rr(w[2] - sk[2*i+1], t[4:0]) ^ u;
      w[0] = rr(w[0] - sk[2*i], u[4:0]) ^ t;
    end
    w[3] = w[3] - sk[1];
    w[1] = w[1] - sk[0];
    return {w[3], w[2], w[1], w[0]};
  endfunction

  // one operation from reset; optionally disturbs the inputs after capture
  task automatic run_op(input bit e, input logic [127:0] d, input bit disturb,
                        output logic [127:0] res, output int lat, output bit addr_ok);
    @(negedge clk);
    rst = 1'b1;
    sel = e;
    din = d;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    lat = -1;
    addr_ok = 1'b1;
    for (int k = 0; k <= LAT + 5; k++) begin
      if (k < NPAIRS) begin
        if (rom_addr !== (e ? AW'(k) : AW'(NPAIRS - 1 - k))) addr_ok = 1'b0;
      end
      if (disturb && k == 2) begin
        sel = ~e;
        din = ~d;
      end
      if (done === 1'b1) begin
        lat = k;
        break;
      end
      @(negedge clk);
    end
    res = dout;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] ct, back, exp, held;
    int lat;
    bit aok;

    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 done in reset", {127'b0, done}, 128'h0);
    chk("R7 data_out in reset", dout, 128'h0);

    for (int v = 0; v < NVEC; v++) begin
      set_key(VKEY[v]);
      exp = ref_enc(VPT[v]);
      run_op(1'b1, VPT[v], 1'b0, ct, lat, aok);
      chk("R1 encrypt vs model", ct, exp);
      if (VKNOWN[v]) chk("R10 R9 published vector", ct, VCT[v]);
      chk("R6 encrypt latency", 128'(lat), 128'(LAT));
      chk("R5 R4 forward address walk", {127'b0, aok}, 128'h1);
      run_op(1'b0, ct, 1'b0, back, lat, aok);
      chk("R2 decrypt round trip", back, VPT[v]);
      chk("R5 R4 reverse address walk", {127'b0, aok}, 128'h1);
    end

    // R3: inputs changed after capture are ignored
    set_key(VKEY[2]);
    exp = ref_enc(VPT[1]);
    run_op(1'b1, VPT[1], 1'b1, ct, lat, aok);
    chk("R3 encrypt with late input change", ct, exp);
    run_op(1'b0, VCT[2], 1'b1, back, lat, aok);
    chk("R3 decrypt with late input change", back, VPT[2]);
    chk("R2 decrypt published ciphertext", back, VPT[2]);

    // R8: result and flag hold after completion
    held = dout;
    sel = ~sel;
    din = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    repeat (10) @(negedge clk);
    chk("R8 data_out held", dout, held);
    chk("R8 done held", {127'b0, done}, 128'h1);

    // R7: reset again clears the outputs
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 data_out cleared by reset", dout, 128'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule